// File: doc/BRIEF.md
# Add-instruction form decoder

This block takes one instruction whose bytes have already been split apart: the prefix flags (operand-size override, REX present with its W, R and B bits, LOCK), the opcode byte, the ModRM byte and a flag that says whether the core runs in 64-bit mode. It reports whether the instruction is an integer add. For an add it also reports:

- the operand form;
- the operand size;
- how many immediate bytes follow and whether the immediate is sign-extended;
- which registers supply the destination and the source, or that an operand lives in memory;
- whether an undefined-opcode fault must be raised.

A front end presents one instruction per cycle with `in_valid`. The decoded result appears on the registered outputs one clock later. Fetching bytes, address calculation and execution are out of scope.

Top module: `add_form_decoder`

## Requirements
- R1: `out_valid` follows `in_valid` by one cycle. `is_add` is 1 exactly when the registered opcode is 0x00 to 0x05, or is 0x80, 0x81 or 0x83 with ModRM bits [5:3] equal to 0. Every other input, including 0x80 to 0x83 with a nonzero ModRM[5:3], gives `is_add`=0 and all decoded fields 0.
- R2: `form` is 0 for opcodes 0x00/0x01 (r/m destination, reg source), 1 for 0x02/0x03 (reg destination, r/m source), 2 for 0x80/0x81/0x83 (r/m destination, immediate source) and 3 for 0x04/0x05 (accumulator destination, immediate source).
- R3: `opsize` is coded 0=8, 1=16, 2=32, 3=64 bits. Opcodes 0x00, 0x02, 0x04 and 0x80 are always 8 bits. The other opcodes are 64 bits when REX.W applies, otherwise 16 bits when the size override is present, otherwise 32 bits. REX.W wins over the size override.
- R4: `imm_len` is coded 0=none, 1=one byte, 2=two bytes, 3=four bytes. Opcodes 0x04, 0x80 and 0x83 take one byte. Opcodes 0x05 and 0x81 take two bytes at 16-bit size and four bytes otherwise. The register forms take none.
- R5: `imm_sext` is 1 for 0x83, and for 0x05 or 0x81 at 64-bit size. Otherwise it is 0.
- R6: The reg field is ModRM[5:3] extended with REX.R in bit 3. When ModRM[7:6]=3 the r/m operand is the register ModRM[2:0] extended with REX.B in bit 3. Any other mod value makes it a memory operand, flagged on `dst_mem`/`src_mem` with index 0.
- R7: At 8-bit size without an applied REX prefix, register codes 4 to 7 select the high byte of registers 0 to 3: the index is code-4 and the `_hi` flag is 1.
- R8: At 8-bit size with any applied REX prefix, register codes 4 to 7 select the low byte of registers 4 to 7, with the `_hi` flag 0.
- R9: `ud_fault` is 1 when an add carries LOCK and its destination is not memory. It is 0 otherwise.
- R10: When `mode64`=0, all REX inputs are ignored. The size is then 16 or 32 bits from the override alone, and the register indices stay within 0 to 7.
- R11: In the accumulator form the destination index is 0, not memory, not high byte. The source is the immediate, so `src_idx`=0 and `src_mem`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| mode64 | input | 1 | Core runs in 64-bit mode |
| pfx_opsize | input | 1 | Operand-size override prefix seen |
| pfx_rex | input | 1 | A REX prefix is present |
| rex_w | input | 1 | REX.W bit |
| rex_r | input | 1 | REX.R bit |
| rex_b | input | 1 | REX.B bit |
| pfx_lock | input | 1 | LOCK prefix seen |
| opcode | input | 8 | Opcode byte |
| modrm | input | 8 | ModRM byte |
| out_valid | output | 1 | Decoded result valid |
| is_add | output | 1 | Instruction is an add |
| form | output | 2 | Operand form (R2) |
| opsize | output | 2 | Operand size code (R3) |
| imm_len | output | 2 | Immediate length code (R4) |
| imm_sext | output | 1 | Immediate is sign-extended (R5) |
| dst_idx | output | 4 | Destination register index |
| dst_hi | output | 1 | Destination is a high-byte register |
| dst_mem | output | 1 | Destination is memory |
| src_idx | output | 4 | Source register index |
| src_hi | output | 1 | Source is a high-byte register |
| src_mem | output | 1 | Source is memory |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
Random vectors draw the opcode mostly from the nine add encodings and their near neighbours 0x82, 0x06 and 0xFF. All prefix bits, `mode64` and the ModRM byte are drawn at random, so every size, REX and mod combination mixes with every form.

Directed cases cover the following:

- The neighbour opcodes and nonzero reg fields under 0x80, 0x81 and 0x83 separate the add group from its siblings.
- Byte codes 4 to 7 with and without a bare REX prefix separate high-byte from low-byte selection.
- REX.W together with the size override shows which of the two wins.
- LOCK with a register destination and with a memory destination shows whether the fault keys on the destination and not on the source.
- REX bits outside 64-bit mode show that they are dropped.

// File: rtl/add_dec_pkg.sv
package add_dec_pkg;

    localparam int IDX_W = 4;

    typedef enum logic [1:0] {
        FORM_RM_DST  = 2'd0,
        FORM_REG_DST = 2'd1,
        FORM_RM_IMM  = 2'd2,
        FORM_ACC_IMM = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0,
        IMM_B1   = 2'd1,
        IMM_B2   = 2'd2,
        IMM_B4   = 2'd3
    } imm_e;

    typedef enum logic [1:0] {
        IK_NONE  = 2'd0,
        IK_BYTE  = 2'd1,
        IK_BSEXT = 2'd2,
        IK_FULL  = 2'd3
    } imm_kind_e;

    typedef struct packed {
        logic             valid;
        logic             is_add;
        form_e            form;
        size_e            size;
        imm_e             imm_len;
        logic             imm_sext;
        logic [IDX_W-1:0] dst_idx;
        logic             dst_hi;
        logic             dst_mem;
        logic [IDX_W-1:0] src_idx;
        logic             src_hi;
        logic             src_mem;
        logic             ud;
    } dec_out_t;

endpackage

// File: rtl/add_opclass.sv
module add_opclass
    import add_dec_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [2:0] grp_sel,
    output logic       hit,
    output form_e      form,
    output logic       byte_op,
    output imm_kind_e  imm_kind
);
    localparam logic [7:0] OP_GRP_B  = 8'h80;
    localparam logic [7:0] OP_GRP_F  = 8'h81;
    localparam logic [7:0] OP_GRP_BS = 8'h83;

    always_comb begin
        hit      = 1'b0;
        form     = FORM_RM_DST;
        byte_op  = 1'b0;
        imm_kind = IK_NONE;
        if (opcode[7:3] == 5'b00000 && opcode[2:1] != 2'b11) begin
            hit     = 1'b1;
            byte_op = ~opcode[0];
            unique case (opcode[2:1])
                2'b00:   form = FORM_RM_DST;
                2'b01:   form = FORM_REG_DST;
                default: begin
                    form     = FORM_ACC_IMM;
                    imm_kind = opcode[0] ? IK_FULL : IK_BYTE;
                end
            endcase
        end else if (grp_sel == 3'd0) begin
            form = FORM_RM_IMM;
            if (opcode == OP_GRP_B) begin
                hit      = 1'b1;
                byte_op  = 1'b1;
                imm_kind = IK_BYTE;
            end else if (opcode == OP_GRP_F) begin
                hit      = 1'b1;
                imm_kind = IK_FULL;
            end else if (opcode == OP_GRP_BS) begin
                hit      = 1'b1;
                imm_kind = IK_BSEXT;
            end
        end
    end
endmodule

// File: rtl/add_size_sel.sv
module add_size_sel
    import add_dec_pkg::*;
(
    input  logic      byte_op,
    input  imm_kind_e imm_kind,
    input  logic      rex_w_eff,
    input  logic      opsize_pfx,
    output size_e     size,
    output imm_e      imm_len,
    output logic      imm_sext
);
    always_comb begin
        if (byte_op)         size = SZ_8;
        else if (rex_w_eff)  size = SZ_64;
        else if (opsize_pfx) size = SZ_16;
        else                 size = SZ_32;

        unique case (imm_kind)
            IK_BYTE: begin
                imm_len  = IMM_B1;
                imm_sext = 1'b0;
            end
            IK_BSEXT: begin
                imm_len  = IMM_B1;
                imm_sext = 1'b1;
            end
            IK_FULL: begin
                imm_len  = (size == SZ_16) ? IMM_B2 : IMM_B4;
                imm_sext = (size == SZ_64);
            end
            default: begin
                imm_len  = IMM_NONE;
                imm_sext = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/add_reg_map.sv
module add_reg_map
    import add_dec_pkg::*;
(
    input  logic [2:0]       code,
    input  logic             ext,
    input  logic             rex_any,
    input  logic             byte_op,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);
    localparam int PAD_W = IDX_W - 3;

    always_comb begin
        if (byte_op && !rex_any && code[2]) begin
            idx = {{(IDX_W-2){1'b0}}, code[1:0]};
            hi  = 1'b1;
        end else begin
            idx = {{(PAD_W-1){1'b0}}, ext, code};
            hi  = 1'b0;
        end
    end
endmodule

// File: rtl/add_form_decoder.sv
module add_form_decoder
    import add_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       mode64,
    input  logic       pfx_opsize,
    input  logic       pfx_rex,
    input  logic       rex_w,
    input  logic       rex_r,
    input  logic       rex_b,
    input  logic       pfx_lock,
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    output logic       out_valid,
    output logic       is_add,
    output logic [1:0] form,
    output logic [1:0] opsize,
    output logic [1:0] imm_len,
    output logic       imm_sext,
    output logic [3:0] dst_idx,
    output logic       dst_hi,
    output logic       dst_mem,
    output logic [3:0] src_idx,
    output logic       src_hi,
    output logic       src_mem,
    output logic       ud_fault
);
    localparam int NOPS = 2;
    localparam int OPD_REG = 0;
    localparam int OPD_RM  = 1;

    dec_out_t  st_d, st_q;

    logic      rex_any, rex_w_e, rex_r_e, rex_b_e;
    logic      hit, byte_op;
    form_e     form_c;
    imm_kind_e imm_kind;
    size_e     size_c;
    imm_e      imm_len_c;
    logic      imm_sext_c;
    logic      rm_is_mem;

    logic [2:0]       opd_code [NOPS];
    logic             opd_ext  [NOPS];
    logic [IDX_W-1:0] opd_idx  [NOPS];
    logic             opd_hi   [NOPS];

    assign rex_any   = mode64 & pfx_rex;
    assign rex_w_e   = rex_any & rex_w;
    assign rex_r_e   = rex_any & rex_r;
    assign rex_b_e   = rex_any & rex_b;
    assign rm_is_mem = (modrm[7:6] != 2'b11);

    assign opd_code[OPD_REG] = modrm[5:3];
    assign opd_ext[OPD_REG]  = rex_r_e;
    assign opd_code[OPD_RM]  = modrm[2:0];
    assign opd_ext[OPD_RM]   = rex_b_e;

    add_opclass u_class (
        .opcode   (opcode),
        .grp_sel  (modrm[5:3]),
        .hit      (hit),
        .form     (form_c),
        .byte_op  (byte_op),
        .imm_kind (imm_kind)
    );

    add_size_sel u_size (
        .byte_op    (byte_op),
        .imm_kind   (imm_kind),
        .rex_w_eff  (rex_w_e),
        .opsize_pfx (pfx_opsize),
        .size       (size_c),
        .imm_len    (imm_len_c),
        .imm_sext   (imm_sext_c)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_opd
        add_reg_map u_map (
            .code    (opd_code[g]),
            .ext     (opd_ext[g]),
            .rex_any (rex_any),
            .byte_op (byte_op),
            .idx     (opd_idx[g]),
            .hi      (opd_hi[g])
        );
    end

    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid;
        if (in_valid && hit) begin
            st_d.is_add   = 1'b1;
            st_d.form     = form_c;
            st_d.size     = size_c;
            st_d.imm_len  = imm_len_c;
            st_d.imm_sext = imm_sext_c;
            unique case (form_c)
                FORM_RM_DST, FORM_RM_IMM: begin
                    st_d.dst_mem = rm_is_mem;
                    st_d.dst_idx = rm_is_mem ? '0 : opd_idx[OPD_RM];
                    st_d.dst_hi  = rm_is_mem ? 1'b0 : opd_hi[OPD_RM];
                    if (form_c == FORM_RM_DST) begin
                        st_d.src_idx = opd_idx[OPD_REG];
                        st_d.src_hi  = opd_hi[OPD_REG];
                    end
                end
                FORM_REG_DST: begin
                    st_d.dst_idx = opd_idx[OPD_REG];
                    st_d.dst_hi  = opd_hi[OPD_REG];
                    st_d.src_mem = rm_is_mem;
                    st_d.src_idx = rm_is_mem ? '0 : opd_idx[OPD_RM];
                    st_d.src_hi  = rm_is_mem ? 1'b0 : opd_hi[OPD_RM];
                end
                default: ;
            endcase
            st_d.ud = pfx_lock & ~st_d.dst_mem;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign is_add    = st_q.is_add;
    assign form      = st_q.form;
    assign opsize    = st_q.size;
    assign imm_len   = st_q.imm_len;
    assign imm_sext  = st_q.imm_sext;
    assign dst_idx   = st_q.dst_idx;
    assign dst_hi    = st_q.dst_hi;
    assign dst_mem   = st_q.dst_mem;
    assign src_idx   = st_q.src_idx;
    assign src_hi    = st_q.src_hi;
    assign src_mem   = st_q.src_mem;
    assign ud_fault  = st_q.ud;
endmodule

// File: rtl/add_form_decoder_chk.sv
module add_form_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       mode64,
    input logic       out_valid,
    input logic       is_add,
    input logic [1:0] form,
    input logic [1:0] opsize,
    input logic [1:0] imm_len,
    input logic       imm_sext,
    input logic [3:0] dst_idx,
    input logic       dst_hi,
    input logic       dst_mem,
    input logic [3:0] src_idx,
    input logic       src_mem,
    input logic       ud_fault
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_add_without_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !is_add && !ud_fault);

    assert_sext_has_imm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        imm_sext |-> imm_len != 2'd0);

    assert_hi_only_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_hi |-> opsize == 2'd0 && dst_idx < 4'd4 && !dst_mem);

    assert_lock_reg_dst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> is_add && !dst_mem);

    assert_legacy_no_rex_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_add && $past(!mode64)) |-> opsize != 2'd3 && !dst_idx[3] && !src_idx[3]);

    assert_acc_dst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_add && form == 2'd3) |-> dst_idx == 4'd0 && !dst_mem && !src_mem && imm_len != 2'd0);
endmodule

bind add_form_decoder add_form_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode64    (mode64),
    .out_valid (out_valid),
    .is_add    (is_add),
    .form      (form),
    .opsize    (opsize),
    .imm_len   (imm_len),
    .imm_sext  (imm_sext),
    .dst_idx   (dst_idx),
    .dst_hi    (dst_hi),
    .dst_mem   (dst_mem),
    .src_idx   (src_idx),
    .src_mem   (src_mem),
    .ud_fault  (ud_fault)
);

// File: tb/tb_add_form_decoder.sv
module tb_add_form_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, mode64 = 1'b0, pfx_opsize = 1'b0, pfx_rex = 1'b0;
    logic       rex_w = 1'b0, rex_r = 1'b0, rex_b = 1'b0, pfx_lock = 1'b0;
    logic [7:0] opcode = 8'h00, modrm = 8'h00;
    logic       out_valid, is_add, imm_sext, dst_hi, dst_mem, src_hi, src_mem, ud_fault;
    logic [1:0] form, opsize, imm_len;
    logic [3:0] dst_idx, src_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    add_form_decoder dut (.*);

    // expected values
    logic       e_add, e_sext, e_dhi, e_dmem, e_shi, e_smem, e_ud;
    logic [1:0] e_form, e_size, e_imm;
    logic [3:0] e_didx, e_sidx;

    task automatic map_reg(input logic [3:0] c, input logic bytes, input logic rx,
                           output logic [3:0] idx, output logic hi);
        if (bytes && !rx && c >= 4) begin idx = c - 4; hi = 1'b1; end
        else begin idx = c; hi = 1'b0; end
    endtask

    task automatic model();
        logic       rx, bytes, mem;
        logic [3:0] rc, mc, ri, mi;
        logic       rh, mh;
        rx    = mode64 && pfx_rex;
        e_add = in_valid && ((opcode <= 8'h05) ||
                ((opcode == 8'h80 || opcode == 8'h81 || opcode == 8'h83) && modrm[5:3] == 3'd0));
        {e_form, e_size, e_imm, e_sext, e_didx, e_dhi, e_dmem, e_sidx, e_shi, e_smem, e_ud} = '0;
        if (!e_add) return;
        bytes  = (opcode == 8'h00 || opcode == 8'h02 || opcode == 8'h04 || opcode == 8'h80);
        e_size = bytes ? 2'd0 : (rx && rex_w) ? 2'd3 : pfx_opsize ? 2'd1 : 2'd2;
        case (opcode)
            8'h00, 8'h01: e_form = 2'd0;
            8'h02, 8'h03: e_form = 2'd1;
            8'h04, 8'h05: e_form = 2'd3;
            default:      e_form = 2'd2;
        endcase
        if (opcode == 8'h04 || opcode == 8'h80 || opcode == 8'h83) e_imm = 2'd1;
        else if (opcode == 8'h05 || opcode == 8'h81) e_imm = (e_size == 2'd1) ? 2'd2 : 2'd3;
        e_sext = (opcode == 8'h83) || ((opcode == 8'h05 || opcode == 8'h81) && e_size == 2'd3);
        rc  = {rx & rex_r, modrm[5:3]};
        mc  = {rx & rex_b, modrm[2:0]};
        mem = modrm[7:6] != 2'b11;
        map_reg(rc, bytes, rx, ri, rh);
        map_reg(mc, bytes, rx, mi, mh);
        if (mem) begin mi = 4'd0; mh = 1'b0; end
        case (e_form)
            2'd0: begin e_didx = mi; e_dhi = mh; e_dmem = mem; e_sidx = ri; e_shi = rh; end
            2'd1: begin e_didx = ri; e_dhi = rh; e_sidx = mi; e_shi = mh; e_smem = mem; end
            2'd2: begin e_didx = mi; e_dhi = mh; e_dmem = mem; end
            default: ;
        endcase
        e_ud = pfx_lock && !e_dmem;
    endtask

    task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (op %02h modrm %02h)",
                     req, what, act, exp, opcode, modrm);
        end
    endtask

    task automatic apply(input logic m64, input logic osz, input logic rex, input logic w,
                         input logic r, input logic b, input logic lock,
                         input logic [7:0] op, input logic [7:0] mr);
        @(negedge clk);
        in_valid = 1'b1; mode64 = m64; pfx_opsize = osz; pfx_rex = rex;
        rex_w = w; rex_r = r; rex_b = b; pfx_lock = lock; opcode = op; modrm = mr;
        model();
        @(posedge clk); #1;
        chk("R1", "out_valid", {3'b0, out_valid}, 4'd1);
        chk("R1", "is_add", {3'b0, is_add}, {3'b0, e_add});
        chk("R2", "form", {2'b0, form}, {2'b0, e_form});
        chk("R3", "opsize", {2'b0, opsize}, {2'b0, e_size});
        chk("R4", "imm_len", {2'b0, imm_len}, {2'b0, e_imm});
        chk("R5", "imm_sext", {3'b0, imm_sext}, {3'b0, e_sext});
        chk("R6", "dst_idx", dst_idx, e_didx);
        chk("R6", "dst_mem", {3'b0, dst_mem}, {3'b0, e_dmem});
        chk("R6", "src_idx", src_idx, e_sidx);
        chk("R6", "src_mem", {3'b0, src_mem}, {3'b0, e_smem});
        chk("R7", "dst_hi", {3'b0, dst_hi}, {3'b0, e_dhi});
        chk("R8", "src_hi", {3'b0, src_hi}, {3'b0, e_shi});
        chk("R9", "ud_fault", {3'b0, ud_fault}, {3'b0, e_ud});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] ops [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
                                 8'h80, 8'h81, 8'h83, 8'h82, 8'h06, 8'hFF};
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset out_valid", {3'b0, out_valid}, 4'd0);
        chk("R1", "reset is_add", {3'b0, is_add}, 4'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: group with nonzero reg field, neighbour opcodes
        apply(1, 0, 0, 0, 0, 0, 0, 8'h81, 8'hC8);
        apply(1, 0, 0, 0, 0, 0, 0, 8'h82, 8'hC0);
        apply(1, 0, 0, 0, 0, 0, 0, 8'h06, 8'hC0);
        // R7: high bytes without REX (AH dst, BH src)
        apply(1, 0, 0, 0, 0, 0, 0, 8'h00, 8'hFC);
        // R8: bare REX selects low bytes 4..7
        apply(1, 0, 1, 0, 0, 0, 0, 8'h00, 8'hFC);
        // R3: REX.W beats size override; R5 sign extension on 0x05/0x81
        apply(1, 1, 1, 1, 0, 0, 0, 8'h05, 8'h00);
        apply(1, 1, 0, 0, 0, 0, 0, 8'h81, 8'hC3);
        apply(1, 0, 1, 1, 1, 1, 0, 8'h81, 8'hC3);
        apply(1, 0, 0, 0, 0, 0, 0, 8'h83, 8'h01);
        // R6: REX.R/B extension
        apply(1, 0, 1, 0, 1, 1, 0, 8'h03, 8'hC9);
        // R9: LOCK on register vs memory destination, memory source
        apply(1, 0, 0, 0, 0, 0, 1, 8'h01, 8'hC1);
        apply(1, 0, 0, 0, 0, 0, 1, 8'h01, 8'h01);
        apply(1, 0, 0, 0, 0, 0, 1, 8'h03, 8'h01);
        // R10: REX ignored outside 64-bit mode
        apply(0, 0, 1, 1, 1, 1, 0, 8'h01, 8'hFF);
        apply(0, 1, 1, 1, 0, 0, 0, 8'h05, 8'h00);
        // R11: accumulator forms
        apply(1, 0, 1, 1, 1, 1, 1, 8'h04, 8'hFF);

        // idle cycle: R1 out_valid drops
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        chk("R1", "idle out_valid", {3'b0, out_valid}, 4'd0);
        chk("R1", "idle is_add", {3'b0, is_add}, 4'd0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            apply(rv[0], rv[1], rv[2], rv[3], rv[4], rv[5], rv[6] & rv[7],
                  ops[$urandom_range(0, 11)], rv[15:8]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule